// File: doc/BRIEF.md
# Front-End Fast Command Decoder with Per-Command Delay

This block sits behind the front-end optical link and takes one 24-bit fast-control word on every bunch-crossing clock. It splits the word into single-bit command strobes and a 4-bit calibration code. Each command passes through its own delay line before it reaches the front-end logic. The word arrives ahead of the crossing it names, and the link cannot skew individual lines, so each delay is tuned to line its command up with that crossing.

The block also runs a local bunch-crossing counter that wraps at a programmable orbit length. The delayed crossing-ID reset command clears this counter and nothing else. On every valid word, the crossing ID carried in the upper field is compared with the local counter. A mismatch sets a sticky error flag, and only an explicit clear input resets that flag. A front-end reset is passed on as a strobe but never disturbs the counter.

Top module: `fe_tfc_decoder`

## Requirements
- R1: While reset is high and right after it, every command strobe, the calibration output, the crossing counter and the error flag read zero.
- R2: Word layout: bits 23..12 are the crossing ID and bits 8..5 the calibration code. The flags are placed as follows, each shown with its output line: bit 11 synch (cmd_o[7]), bit 10 non-zero-suppressed readout (cmd_o[6]), bit 9 header-only (cmd_o[5]), bit 4 crossing-ID reset (cmd_o[4]), bit 3 front-end reset (cmd_o[3]), bit 2 crossing veto (cmd_o[2]), bit 1 snapshot (cmd_o[1]) and bit 0 spare (cmd_o[0]). A word sampled with the valid input low issues no command.
- R3: Command line i uses delay value d = delay_cfg_i[5i+4:5i], which ranges from 0 to 31. A flag sampled at clock edge k appears on its output line after edge k+d and stays there for exactly one cycle.
- R4: The lines are independent. Commands in one word that have different delays come out in different cycles, each at its own delay.
- R5: The calibration code uses the delay in delay_cfg_i[44:40]. calib_type_o shows the delayed code for one cycle and is zero otherwise.
- R6: The crossing counter increments once per cycle. In the cycle after it reaches orbit_len_i-1 (or any higher value) it reads 0. The nominal orbit length is 3564.
- R7: When the delayed crossing-ID reset strobe is high, the counter reads 0 after the next edge.
- R8: The delayed front-end reset strobe has no effect on the counter or on the error flag.
- R9: A word sampled with the valid input high sets the error flag if its crossing ID differs from the counter value at that edge. Words sampled with the valid input low are not compared.
- R10: The error flag stays set until err_clr_i is sampled high. A mismatch in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| tfc_word_i | input | 24 | Received fast-control word |
| tfc_valid_i | input | 1 | Word qualifier |
| delay_cfg_i | input | 45 | Nine 5-bit delays (eight flags, then calibration) |
| orbit_len_i | input | 12 | Crossings per orbit |
| err_clr_i | input | 1 | Clears the sticky mismatch flag |
| cmd_o | output | 8 | Delayed command strobes |
| calib_type_o | output | 4 | Delayed calibration code |
| bx_cnt_o | output | 12 | Local crossing counter |
| sync_err_o | output | 1 | Sticky crossing-ID mismatch flag |

## Verification
The bench drives delays at both extremes, 0 and 31, and mixes different delays within a single word. An off-by-one in the tap select would shift every strobe by a cycle, and a shared pipeline would make all commands come out together. It shortens the orbit so that wrap-around happens often, and it also runs one full nominal orbit; a compare against the wrong bound would either skip crossing 0 or run one crossing too far. It also sends a front-end reset, a delayed counter reset, mismatching IDs with the valid input both high and low, and a clear that lands together with a mismatch. These catch a counter tied to the wrong strobe, a comparison that ignores the valid input, and a clear given priority over a new error.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int WORD_W = 24;
  localparam int ID_W   = 12;
  localparam int ID_LSB = 12;
  localparam int CAL_W  = 4;
  localparam int CAL_LSB = 5;
  localparam int NFLAG  = 8;

  typedef enum int {
    CH_SPARE = 0, CH_SNAP = 1, CH_VETO = 2, CH_FERST = 3,
    CH_BXRST = 4, CH_HDR = 5, CH_NZS = 6, CH_SYNC = 7
  } flag_ch_e;

  // word bit of flag line i: lines 0..4 at bits 0..4, lines 5..7 at bits 9..11
  function automatic int flag_pos(input int i);
    return (i < 5) ? i : i + 4;
  endfunction
endpackage

// File: rtl/tfc_field_split.sv
module tfc_field_split
  import tfc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic [NFLAG-1:0]  flags_o,
  output logic [CAL_W-1:0]  cal_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flags_o[i] = valid_i & word_i[flag_pos(i)];
  end
  assign cal_o = valid_i ? word_i[CAL_LSB +: CAL_W] : '0;
endmodule

// File: rtl/tfc_delay_line.sv
module tfc_delay_line #(
  parameter int W     = 1,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [DLY_W-1:0] dly,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) stage[j] <= '0;
      dout <= '0;
    end else begin
      stage[0] <= din;
      for (int j = 1; j < DEPTH; j++) stage[j] <= stage[j-1];
      dout <= (dly == '0) ? din : stage[dly - 1'b1];
    end
  end
endmodule

// File: rtl/tfc_bx_counter.sv
module tfc_bx_counter #(
  parameter int ID_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] orbit_len,
  input  logic            clr_strobe,
  input  logic            id_valid,
  input  logic [ID_W-1:0] id_rx,
  input  logic            err_clr,
  output logic [ID_W-1:0] bx_cnt,
  output logic            sync_err
);
  logic [ID_W-1:0] last_bx;
  assign last_bx = orbit_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bx_cnt   <= '0;
      sync_err <= 1'b0;
    end else begin
      if (clr_strobe || bx_cnt >= last_bx) bx_cnt <= '0;
      else                                 bx_cnt <= bx_cnt + 1'b1;
      sync_err <= (sync_err & ~err_clr) | (id_valid && (id_rx != bx_cnt));
    end
  end
endmodule

// File: rtl/fe_tfc_decoder.sv
module fe_tfc_decoder
  import tfc_pkg::*;
#(
  parameter int DLY_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WORD_W-1:0]          tfc_word_i,
  input  logic                       tfc_valid_i,
  input  logic [(NFLAG+1)*DLY_W-1:0] delay_cfg_i,
  input  logic [ID_W-1:0]            orbit_len_i,
  input  logic                       err_clr_i,
  output logic [NFLAG-1:0]           cmd_o,
  output logic [CAL_W-1:0]           calib_type_o,
  output logic [ID_W-1:0]            bx_cnt_o,
  output logic                       sync_err_o
);
  logic [NFLAG-1:0] flags;
  logic [CAL_W-1:0] cal;
  logic [NFLAG-1:0] cmd_q;

  tfc_field_split u_split (
    .word_i (tfc_word_i),
    .valid_i(tfc_valid_i),
    .flags_o(flags),
    .cal_o  (cal)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_line
    tfc_delay_line #(.W(1), .DLY_W(DLY_W)) u_dly (
      .clk (clk),
      .rst (rst),
      .din (flags[i]),
      .dly (delay_cfg_i[i*DLY_W +: DLY_W]),
      .dout(cmd_q[i])
    );
  end

  tfc_delay_line #(.W(CAL_W), .DLY_W(DLY_W)) u_cal_dly (
    .clk (clk),
    .rst (rst),
    .din (cal),
    .dly (delay_cfg_i[NFLAG*DLY_W +: DLY_W]),
    .dout(calib_type_o)
  );

  tfc_bx_counter #(.ID_W(ID_W)) u_bx (
    .clk       (clk),
    .rst       (rst),
    .orbit_len (orbit_len_i),
    .clr_strobe(cmd_q[CH_BXRST]),
    .id_valid  (tfc_valid_i),
    .id_rx     (tfc_word_i[ID_LSB +: ID_W]),
    .err_clr   (err_clr_i),
    .bx_cnt    (bx_cnt_o),
    .sync_err  (sync_err_o)
  );

  assign cmd_o = cmd_q;
endmodule

// File: rtl/tfc_chk.sv
module tfc_chk
  import tfc_pkg::*;
#(
  parameter int DLY_W = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic [WORD_W-1:0]          tfc_word_i,
  input logic                       tfc_valid_i,
  input logic [(NFLAG+1)*DLY_W-1:0] delay_cfg_i,
  input logic [ID_W-1:0]            orbit_len_i,
  input logic                       err_clr_i,
  input logic [NFLAG-1:0]           cmd_o,
  input logic [CAL_W-1:0]           calib_type_o,
  input logic [ID_W-1:0]            bx_cnt_o,
  input logic                       sync_err_o
);
  logic            past_ok;
  logic            prev_rst;
  logic [ID_W-1:0] orb_m1;
  logic [DLY_W-1:0] ferst_dly;
  logic            mismatch;

  assign orb_m1    = orbit_len_i - 1'b1;
  assign ferst_dly = delay_cfg_i[CH_FERST*DLY_W +: DLY_W];
  assign mismatch  = tfc_valid_i && (tfc_word_i[ID_LSB +: ID_W] != bx_cnt_o);

  always_ff @(posedge clk) begin
    past_ok  <= !rst;
    prev_rst <= rst;
  end

  always_ff @(posedge clk) begin
    if (prev_rst === 1'b1)
      a_r1_reset_clear: assert (cmd_o == '0 && calib_type_o == '0 &&
                                bx_cnt_o == '0 && !sync_err_o);
  end

  a_r6_count_step: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(!cmd_o[CH_BXRST]) && $past(bx_cnt_o) < $past(orb_m1))
      |-> bx_cnt_o == ID_W'($past(bx_cnt_o) + 1'b1));

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(bx_cnt_o) >= $past(orb_m1)) |-> bx_cnt_o == '0);

  a_r7_bx_clear: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(cmd_o[CH_BXRST]) |-> bx_cnt_o == '0);

  a_r3_zero_delay: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(ferst_dly) == '0)
      |-> cmd_o[CH_FERST] == $past(tfc_valid_i & tfc_word_i[flag_pos(CH_FERST)]));

  a_r9_mismatch_sets: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(mismatch) |-> sync_err_o);

  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(sync_err_o) && !$past(err_clr_i)) |-> sync_err_o);
endmodule

bind fe_tfc_decoder tfc_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tfc_word_i  (tfc_word_i),
  .tfc_valid_i (tfc_valid_i),
  .delay_cfg_i (delay_cfg_i),
  .orbit_len_i (orbit_len_i),
  .err_clr_i   (err_clr_i),
  .cmd_o       (cmd_o),
  .calib_type_o(calib_type_o),
  .bx_cnt_o    (bx_cnt_o),
  .sync_err_o  (sync_err_o)
);

// File: tb/tb_fe_tfc_decoder.sv
module tb_fe_tfc_decoder;
  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] word = '0;
  logic        valid = 0;
  logic [44:0] dcfg;
  logic [11:0] orbit = 12'd3564;
  logic        eclr = 0;
  logic [7:0]  cmd;
  logic [3:0]  cal;
  logic [11:0] bx;
  logic        serr;

  int dly [9];
  int n_chk = 0, n_bad = 0;
  string cur = "R1";
  bit cmp_on = 0;

  logic [23:0] hist [$];
  logic [7:0]  m_cmd;
  logic [3:0]  m_cal;
  int          m_bx;
  bit          m_err;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < 9; i++) dcfg[i*5 +: 5] = 5'(dly[i]);

  fe_tfc_decoder dut (
    .clk(clk), .rst(rst), .tfc_word_i(word), .tfc_valid_i(valid),
    .delay_cfg_i(dcfg), .orbit_len_i(orbit), .err_clr_i(eclr),
    .cmd_o(cmd), .calib_type_o(cal), .bx_cnt_o(bx), .sync_err_o(serr)
  );

  function automatic int fpos(int i);
    return (i < 5) ? i : i + 4;
  endfunction

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    if (rst) begin
      hist = {};
      for (int i = 0; i < 32; i++) hist.push_back(24'd0);
      m_cmd = 0; m_cal = 0; m_bx = 0; m_err = 0;
    end else begin
      int nbx;
      bit nerr;
      nbx  = (m_cmd[4] || m_bx >= int'(orbit) - 1) ? 0 : m_bx + 1;
      nerr = (m_err && !eclr) || (valid && int'(word[23:12]) != m_bx);
      hist.push_front(valid ? word : 24'd0);
      void'(hist.pop_back());
      for (int c = 0; c < 8; c++) m_cmd[c] = hist[dly[c]][fpos(c)];
      m_cal = hist[dly[8]][8:5];
      m_bx = nbx; m_err = nerr;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      check(cur, "cmd", int'(cmd), int'(m_cmd));
      check(cur, "calib", int'(cal), int'(m_cal));
      check(cur, "bx", int'(bx), m_bx);
      check(cur, "err", int'(serr), int'(m_err));
    end
  end

  task automatic send(logic [7:0] f, logic [3:0] c, bit v, int id_off = 0, bit clr = 0);
    logic [23:0] w;
    @(negedge clk);
    w = '0;
    w[23:12] = 12'(m_bx + id_off);
    w[8:5] = c;
    for (int i = 0; i < 8; i++) w[fpos(i)] = f[i];
    word = w; valid = v; eclr = clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send(8'h00, 4'h0, 1);
  endtask

  task automatic set_all(int d);
    @(negedge clk);
    for (int i = 0; i < 9; i++) dly[i] = d;
  endtask

  initial begin
    for (int i = 0; i < 9; i++) dly[i] = 0;
    repeat (3) @(posedge clk);
    cmp_on = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    cur = "R1"; idle(2);

    cur = "R2";
    for (int i = 0; i < 8; i++) begin send(8'(1 << i), 4'h0, 1); idle(2); end
    send(8'hFF, 4'hF, 0, 5); idle(3);

    cur = "R3";
    foreach (dly[k]) begin end
    for (int d = 0; d < 32; d += 5) begin
      set_all(d); idle(33);
      send(8'hA5, 4'h0, 1); idle(d + 2);
      send(8'h5A, 4'h0, 1); send(8'h5A, 4'h0, 1); idle(d + 3);
    end
    set_all(31); idle(33); send(8'hFF, 4'h0, 1); idle(34);

    cur = "R4";
    @(negedge clk);
    for (int i = 0; i < 9; i++) dly[i] = 3 * i + 1;
    idle(33); send(8'hEF, 4'h9, 1); idle(30); send(8'h6B, 4'h3, 1); send(8'h00, 4'h6, 1); idle(30);

    cur = "R5";
    set_all(0); idle(33);
    for (int c = 0; c < 16; c++) send(8'h00, 4'(c), 1);
    @(negedge clk); dly[8] = 31; idle(33);
    send(8'h00, 4'hC, 1); send(8'h00, 4'h3, 0); idle(34);

    cur = "R6";
    set_all(0); @(negedge clk); orbit = 12'd16; idle(50);
    @(negedge clk); orbit = 12'd5; idle(20);
    @(negedge clk); orbit = 12'd3564; idle(3600);

    cur = "R7";
    @(negedge clk); dly[4] = 3; idle(33);
    idle(40); send(8'h10, 4'h0, 1); idle(10);
    @(negedge clk); dly[4] = 0; idle(33);
    send(8'h10, 4'h0, 1); idle(6);

    cur = "R8";
    @(negedge clk); dly[3] = 7; idle(33);
    send(8'h08, 4'h0, 1); idle(12); send(8'h08, 4'h0, 1); send(8'h08, 4'h0, 1); idle(12);

    cur = "R9";
    send(8'h00, 4'h0, 0, 9); idle(4);
    send(8'h00, 4'h0, 1, 1); idle(6);
    send(8'h00, 4'h0, 1, -1); idle(3);

    cur = "R10";
    send(8'h00, 4'h0, 1, 0, 1); idle(3);
    send(8'h00, 4'h0, 1, 2); idle(3);
    send(8'h00, 4'h0, 1, 3, 1); idle(3);
    send(8'h00, 4'h0, 0, 4, 1); idle(3);

    cur = "R1";
    @(negedge clk); rst = 1; valid = 0; repeat (3) @(negedge clk);
    rst = 0; idle(3);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog run hung actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule